// File: doc/BRIEF.md
# Sensor Sampling Interval Sequencer

The sequencer decides when each of four sensing points is sampled. A free-running prescaler turns the input clock into a period tick. Each tick lasts `period_unit * PRESCALE` clock cycles, with a default prescale of 256. For example, a period value of 12 on a 26 MHz clock gives a tick of roughly 118 us. All spacing is counted in whole ticks.

A round visits the enabled sensors in ascending index order. For each sensor it takes a burst of samples, spaced by the filter gap. The sensor gap separates the last sample of one sensor from the first sample of the next enabled sensor. After the highest enabled sensor, the round gap applies and the round starts again at the lowest enabled sensor.

A sensor marked in the immediate mask takes one sample and imposes no delay after it. Each sample is announced by a one-cycle `req` strobe, which carries the sensor number on `req_idx`. Filtering and threshold comparison take place downstream.

Top module: `sample_sequencer`

## Requirements
- R1: During reset and on the first cycle after reset is released, `req` is low, and the sequencer is idle.
- R2: A period tick occurs once every `period_unit * PRESCALE` clock cycles. When `period_unit` is 0, a tick occurs on every cycle.
- R3: Each sensor that is not immediate receives `burst_len + 1` consecutive samples. Consecutive samples of the same sensor are `filter_gap + 1` ticks apart.
- R4: The first sample of the next enabled sensor comes `sensor_gap + 1` ticks after the last sample of the previous sensor.
- R5: After the highest enabled sensor, the next sample goes to the lowest enabled sensor, `round_gap + 1` ticks later.
- R6: Sensors are visited in ascending index order, and bit i of `sensor_en` enables sensor i. A disabled sensor is skipped and uses up no interval.
- R7: A sensor whose bit is set in `imm_en` (bit i for sensor i) takes exactly one sample per round, whatever `burst_len` is. The next step then follows on the very next tick.
- R8: A gap value of 0 places the next step on the very next tick.
- R9: While `sensor_en` is all zero, no request is issued and the sequencer returns to idle. When an enable is set again, the next tick samples the lowest enabled sensor.
- R10: `req` is high for exactly one cycle per sample. `req_idx` names an enabled sensor while `req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sensor_en | input | 4 | Sensor enables, bit i enables sensor i |
| imm_en | input | 4 | Immediate-mode mask, bit i for sensor i |
| period_unit | input | 10 | Tick length in units of PRESCALE cycles |
| filter_gap | input | 10 | Ticks between samples of one sensor, minus one |
| sensor_gap | input | 10 | Ticks between sensors, minus one |
| round_gap | input | 10 | Ticks between rounds, minus one |
| burst_len | input | 3 | Samples per sensor, minus one |
| req | output | 1 | One-cycle sample request strobe |
| req_idx | output | 2 | Sensor to sample, valid with req |

## Verification
The hardest case to reach from the ports mixes immediate and filtered sensors in one round. In that case the zero delay after an immediate sample must be followed by a full filtered burst, and then by the round gap back to the immediate sensor. The stimulus sets up that mix with a short tick. It then checks the exact order of the requests and the cycle spacing between each pair. It also clears every enable in the middle of a run, confirms that no request appears, and re-enables a single high-index sensor.

// File: rtl/sample_sequencer.sv
module sample_sequencer #(
  parameter int PRESCALE = 256,
  parameter int PU_W     = 10,
  parameter int GAP_W    = 10,
  parameter int BURST_W  = 3,
  parameter int NSENS    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSENS-1:0]         sensor_en,
  input  logic [NSENS-1:0]         imm_en,
  input  logic [PU_W-1:0]          period_unit,
  input  logic [GAP_W-1:0]         filter_gap,
  input  logic [GAP_W-1:0]         sensor_gap,
  input  logic [GAP_W-1:0]         round_gap,
  input  logic [BURST_W-1:0]       burst_len,
  output logic                     req,
  output logic [$clog2(NSENS)-1:0] req_idx
);
  localparam int IDX_W = $clog2(NSENS);
  localparam int PC_W  = PU_W + $clog2(PRESCALE) + 1;

  logic [PC_W-1:0]    pcnt, limit;
  logic               tick;
  logic               busy;
  logic [IDX_W-1:0]   tgt, low_idx, above_idx, fire_s;
  logic [BURST_W-1:0] cnt, cnt_fire;
  logic [GAP_W-1:0]   wait_cnt;
  logic               above_ok, any_en, do_fire, go_idle, last_of_burst;

  assign limit = PC_W'(period_unit) * PC_W'(PRESCALE);
  assign tick  = (pcnt + 1'b1) >= limit;

  always_ff @(posedge clk) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  assign any_en   = |sensor_en;
  assign fire_s   = busy ? tgt : low_idx;
  assign cnt_fire = busy ? cnt : '0;

  always_comb begin
    low_idx   = '0;
    above_idx = '0;
    above_ok  = 1'b0;
    for (int i = NSENS - 1; i >= 0; i--) begin
      if (sensor_en[i]) low_idx = IDX_W'(i);
      if (sensor_en[i] && i > int'(fire_s)) begin
        above_idx = IDX_W'(i);
        above_ok  = 1'b1;
      end
    end
  end

  assign last_of_burst = imm_en[fire_s] || (cnt_fire >= burst_len);
  assign do_fire = tick && any_en && (!busy || (wait_cnt == '0 && sensor_en[tgt]));
  assign go_idle = !any_en || (tick && busy && wait_cnt == '0 && !sensor_en[tgt]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= 1'b0;
      req_idx  <= '0;
      busy     <= 1'b0;
      tgt      <= '0;
      cnt      <= '0;
      wait_cnt <= '0;
    end else begin
      req <= do_fire;
      if (do_fire) req_idx <= fire_s;
      if (go_idle) begin
        busy <= 1'b0;
      end else if (do_fire) begin
        busy <= 1'b1;
        if (!last_of_burst) begin
          tgt      <= fire_s;
          cnt      <= cnt_fire + 1'b1;
          wait_cnt <= filter_gap;
        end else begin
          cnt      <= '0;
          tgt      <= above_ok ? above_idx : low_idx;
          wait_cnt <= imm_en[fire_s] ? '0 : (above_ok ? sensor_gap : round_gap);
        end
      end else if (tick && busy && wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !req);
  assert_req_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && $past(rst_n)) |-> $past(tick));
  assert_req_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (($past(sensor_en) >> req_idx) & NSENS'(1)) != '0);
  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sensor_en) == '0) |-> !req);
  assert_idx_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !$isunknown(req_idx));
endmodule

// File: tb/sample_sequencer_test.sv
module sample_sequencer_test;
  localparam int PS = 4;
  logic clk = 0, rst_n = 0;
  logic [3:0] en = 0, imm = 0;
  logic [9:0] pu = 1, fg = 0, sg = 0, rg = 0;
  logic [2:0] bl = 0;
  logic req;
  logic [1:0] req_idx;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sample_sequencer #(.PRESCALE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .sensor_en(en), .imm_en(imm), .period_unit(pu),
    .filter_gap(fg), .sensor_gap(sg), .round_gap(rg), .burst_len(bl),
    .req(req), .req_idx(req_idx));

  // behavioural reference: absolute tick numbers and due times
  int m_pc, m_ticks, m_due, m_tgt, m_cnt, m_idx;
  bit m_busy, m_req;

  function automatic int lowest(input logic [3:0] m);
    for (int j = 0; j < 4; j++) if (m[j]) return j;
    return 0;
  endfunction

  task automatic model_fire(input int s, input int c);
    int g, n;
    m_req = 1; m_idx = s; m_busy = 1;
    if (!imm[s] && c < int'(bl)) begin
      m_tgt = s; m_cnt = c + 1; g = int'(fg);
    end else begin
      n = -1;
      for (int j = s + 1; j < 4; j++) if (en[j] && n < 0) n = j;
      if (n >= 0) begin m_tgt = n; g = int'(sg); end
      else begin m_tgt = lowest(en); g = int'(rg); end
      m_cnt = 0;
      if (imm[s]) g = 0;
    end
    m_due = m_ticks + 1 + g;
  endtask

  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      m_pc = 0; m_busy = 0; m_req = 0; m_ticks = 0;
    end else begin
      m_req = 0;
      tk = (m_pc + 1 >= int'(pu) * PS);
      m_pc = tk ? 0 : m_pc + 1;
      if (tk) m_ticks++;
      if (en == 0) m_busy = 0;
      else if (tk) begin
        if (!m_busy) model_fire(lowest(en), 0);
        else if (m_ticks >= m_due) begin
          if (en[m_tgt]) model_fire(m_tgt, m_cnt);
          else m_busy = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!done && rst_n) begin
      total++;
      if (req !== m_req || (m_req && req_idx !== 2'(m_idx))) begin
        bad++;
        $display("FAIL R10 model compare: req=%0b idx=%0d expected req=%0b idx=%0d",
                 req, req_idx, m_req, m_idx);
      end
    end
    if (cycles > 100000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_req(output int idx, output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!req && gap < 3000);
    idx = int'(req_idx);
    if (!req) check("watchdog req wait", 0, 1);
  endtask

  task automatic pause;
    en = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_seq(input string tag, input int n, input int exp_idx[], input int exp_gap[]);
    int idx, gap;
    for (int k = 0; k < n; k++) begin
      next_req(idx, gap);
      check({tag, " idx"}, idx, exp_idx[k]);
      if (k > 0) check({tag, " gap"}, gap, exp_gap[k-1]);
    end
  endtask

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    check("R1 req low in reset", int'(req), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 req low after reset", int'(req), 0);

    // R3 R4 R5 R6: tick = 8 cycles, sensors 0 and 2, two samples each
    pu = 2; bl = 1; fg = 1; sg = 2; rg = 3; imm = 0; en = 4'b0101;
    run_seq("R3/R4/R5/R6 bursts", 5, '{0, 0, 2, 2, 0}, '{16, 24, 16, 32});
    pause();

    // R2 R8: period 0 means tick every cycle, all gaps zero
    pu = 0; bl = 0; fg = 0; sg = 0; rg = 0; en = 4'b1111;
    run_seq("R2/R8 zero gaps", 6, '{0, 1, 2, 3, 0, 1}, '{1, 1, 1, 1, 1});
    pause();

    // R7: sensor 0 immediate, sensor 1 bursts of three
    pu = 1; bl = 2; fg = 1; sg = 5; rg = 2; imm = 4'b0001; en = 4'b0011;
    run_seq("R7 immediate", 6, '{0, 1, 1, 1, 0, 1}, '{4, 8, 8, 12, 4});
    pause();
    imm = 0;

    // R9: all enables cleared, nothing issued
    cnt = 0;
    repeat (60) begin @(negedge clk); if (req) cnt++; end
    check("R9 no req while disabled", cnt, 0);

    // R9 R6: restart on single high sensor
    pu = 1; bl = 0; rg = 1; en = 4'b1000;
    run_seq("R9/R6 restart", 3, '{3, 3, 3}, '{8, 8});
    en = 0;
    @(negedge clk);
    cnt = 0;
    repeat (40) begin @(negedge clk); if (req) cnt++; end
    check("R9 idle after clear", cnt, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule